// File: doc/BRIEF.md
# EDO DRAM Access Controller with CAS-before-RAS Refresh

This block sits between a simple host request port and one 8M x 8 extended-data-out DRAM. Each accepted host request (one byte, read or write) becomes a full random-access DRAM cycle. The row half of the address goes out on a shared address bus, RAS# falls, the column half follows, and CAS# falls. Write data is driven before CAS# falls. For a read, the byte is captured on the last cycle of CAS# low and returned with a one-cycle valid pulse.

A free-running interval timer raises refresh requests. The controller answers each one with a CAS-before-RAS cycle, so the device supplies the row itself and no refresh address is kept. A pending refresh takes precedence over host traffic. It is never started in the middle of an access; it waits for that access to finish. The memory geometry (4,096 rows by 2,048 columns, or 8,192 rows by 1,024 columns), the speed grade and the clock period are parameters. All nanosecond timings are turned into cycle counts at elaboration.

Top module: `edo_ctrl`

## Requirements
- R1: The 23-bit host address is split with the row in the upper bits. With BIG_ROWS=0 the row is addr[22:11] and the column is addr[10:0], on a 12-bit bus. With BIG_ROWS=1 the row is addr[22:10] and the column is addr[9:0], on a 13-bit bus. The column is zero-extended in the upper bus bits. The row is on the bus when RAS# falls and the column is on the bus when CAS# falls.
- R2: After reset, RAS#, CAS#, WE# and OE# are high, req_ready is high and rd_valid is low.
- R3: On an access, RAS# stays low for exactly ceil(tRAC/T) cycles. CAS# falls ceil(tRAC/T) - ceil(tCAC/T) cycles after RAS# falls and rises together with RAS#. For grade 5 at a 5 ns clock this gives 10, 7 and 3 cycles.
- R4: On a read, OE# is low only while CAS# is low. dram_dq_in is captured on the last CAS#-low cycle and returned on rd_data with a single-cycle rd_valid pulse. The byte returned is the one last written to that address.
- R5: On a write, WE# is low and dram_dq_oe is high with the write byte on dram_dq_out from before CAS# falls until CAS# rises. OE# stays high throughout.
- R6: Two successive falling edges of RAS# are at least ceil(tRC/T) cycles apart (17 for grade 5 at 5 ns).
- R7: A refresh cycle drops CAS# at least one cycle before RAS# and keeps WE# high. It then holds both strobes low for ceil(tRAC/T) cycles.
- R8: A refresh request is raised every ceil(REFI_NS/T) cycles. The default of 15,625 ns gives 4,096 refreshes per 64 ms.
- R9: While a refresh is pending, req_ready is low and the idle controller starts the refresh before any host request. A refresh that falls due during an access starts once that access has finished.
- R10: Timing parameters come from the speed grade (5: tRC 84, tRAC 50, tCAC 13, tCAS 8 ns; 6: 104, 60, 15, 10 ns). Each is rounded up to whole cycles of CLK_NS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 23 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse, rd_data holds read byte |
| rd_data | output | 8 | Read byte |
| dram_ma | output | 12 or 13 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Write data toward the device |
| dram_dq_oe | output | 1 | Controller drives the data bus |
| dram_dq_in | input | 8 | Read data from the device |

## Verification
The bench aims at the address split at the row/column boundary and at the all-ones address. A wrong split would store bytes at aliased locations, and those bytes would then read back wrong. It measures the RAS#-to-CAS# delay and both pulse widths. A design that rounds down, or that lets CAS# fall too early, shows a shorter count, and its model returns garbage data. It streams back-to-back reads across several refresh intervals. A controller that lets host traffic win would starve refresh, and the refresh count would fall short. Every refresh edge is also checked for CAS# leading RAS# with WE# high.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

  typedef enum logic [1:0] {TK_RC, TK_RAC, TK_CAC, TK_CASW} tkind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_ACT, S_PRE, S_RCAS, S_RRAS, S_RPRE
  } seq_e;

  // nanoseconds for one timing kind at one speed grade
  function automatic int grade_ns(int grade, tkind_e k);
    case (k)
      TK_RC:   return (grade == 6) ? 104 : 84;
      TK_RAC:  return (grade == 6) ? 60  : 50;
      TK_CAC:  return (grade == 6) ? 15  : 13;
      default: return (grade == 6) ? 10  : 8;
    endcase
  endfunction

  // round a nanosecond span up to whole clock cycles
  function automatic int to_cyc(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_addr_mux.sv
`timescale 1ns/1ps
module edo_addr_mux #(
  parameter int ADDR_W = 23,
  parameter int ROW_W  = 12,
  parameter int MA_W   = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              col_phase,
  output logic [MA_W-1:0]   ma
);
  localparam int COL_W = ADDR_W - ROW_W;

  logic [MA_W-1:0] row_f;
  logic [MA_W-1:0] col_f;

  generate
    if (MA_W > COL_W) begin : g_col_pad
      assign col_f = {{(MA_W-COL_W){1'b0}}, addr[COL_W-1:0]};
    end else begin : g_col_full
      assign col_f = addr[COL_W-1:0];
    end
    if (MA_W > ROW_W) begin : g_row_pad
      assign row_f = {{(MA_W-ROW_W){1'b0}}, addr[ADDR_W-1:COL_W]};
    end else begin : g_row_full
      assign row_f = addr[ADDR_W-1:COL_W];
    end
  endgenerate

  assign ma = col_phase ? col_f : row_f;

endmodule

// File: rtl/edo_refresh_sched.sv
`timescale 1ns/1ps
module edo_refresh_sched #(
  parameter int INTERVAL = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pending
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end

  // R8: every interval tick leaves a request pending
  assert_tick_pends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pending);

  // R9: the sequencer only acknowledges a request that exists
  assert_ack_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pending);

endmodule

// File: rtl/edo_ctrl.sv
`timescale 1ns/1ps
module edo_ctrl
  import edo_pkg::*;
#(
  parameter bit BIG_ROWS = 1'b0,
  parameter int GRADE    = 5,
  parameter int CLK_NS   = 5,
  parameter int REFI_NS  = 15625,
  parameter int ADDR_W   = 23,
  parameter int DATA_W   = 8,
  localparam int MA_W    = BIG_ROWS ? 13 : 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [MA_W-1:0]   dram_ma,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int ROW_W   = MA_W;
  localparam int RC      = to_cyc(grade_ns(GRADE, TK_RC),   CLK_NS);
  localparam int RAC     = to_cyc(grade_ns(GRADE, TK_RAC),  CLK_NS);
  localparam int CAC     = to_cyc(grade_ns(GRADE, TK_CAC),  CLK_NS);
  localparam int CASW    = to_cyc(grade_ns(GRADE, TK_CASW), CLK_NS);
  localparam int RCD     = imax(1, RAC - imax(CAC, CASW));
  localparam int CAS_END = imax(RAC, RCD + imax(CAC, CASW));
  localparam int PRE_A   = imax(1, RC - CAS_END);
  localparam int PRE_R   = imax(1, RC - RAC);
  localparam int REFI    = to_cyc(REFI_NS, CLK_NS);
  localparam int CNT_W   = $clog2(imax(imax(CAS_END, PRE_A), imax(RAC, PRE_R)) + 1);
  localparam int CHK_W   = $clog2(imax(RC, CAS_END + 1) + 1);

  seq_e              state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] a_q;
  logic              wr_q;
  logic [DATA_W-1:0] wd_q;

  // named internal events
  logic ref_pending, ref_ack, accept, col_phase, rd_capture, act_last;

  assign ref_ack    = (state == S_IDLE) && ref_pending;
  assign req_ready  = (state == S_IDLE) && !ref_pending;
  assign accept     = req_valid && req_ready;
  assign col_phase  = (state == S_ACT) && (cnt >= CNT_W'(RCD));
  assign act_last   = (state == S_ACT) && (cnt == CNT_W'(CAS_END - 1));
  assign rd_capture = act_last && !wr_q;

  edo_refresh_sched #(.INTERVAL(REFI)) u_sched (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pending)
  );

  edo_addr_mux #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .MA_W(MA_W)) u_mux (
    .addr(a_q), .col_phase(col_phase), .ma(dram_ma)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      a_q      <= '0;
      wr_q     <= 1'b0;
      wd_q     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_capture;
      if (rd_capture) rd_data <= dram_dq_in;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (ref_pending) state <= S_RCAS;
          else if (accept) begin
            a_q   <= req_addr;
            wr_q  <= req_write;
            wd_q  <= req_wdata;
            state <= S_SETUP;
          end
        end
        S_SETUP: begin state <= S_ACT; cnt <= '0; end
        S_ACT: begin
          if (act_last) begin state <= S_PRE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_PRE: begin
          if (cnt == CNT_W'(PRE_A - 1)) begin state <= S_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_RCAS: begin state <= S_RRAS; cnt <= '0; end
        S_RRAS: begin
          if (cnt == CNT_W'(RAC - 1)) begin state <= S_RPRE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_RPRE: begin
          if (cnt == CNT_W'(PRE_R - 1)) begin state <= S_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dram_ras_n  = !((state == S_ACT) || (state == S_RRAS));
  assign dram_cas_n  = !(col_phase || (state == S_RCAS) || (state == S_RRAS));
  assign dram_we_n   = !(wr_q && ((state == S_SETUP) || (state == S_ACT)));
  assign dram_oe_n   = !(col_phase && !wr_q);
  assign dram_dq_oe  = wr_q && ((state == S_SETUP) || (state == S_ACT));
  assign dram_dq_out = wd_q;

  // ---------------- checker logic ----------------
  logic [CHK_W-1:0] gap_cnt, low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= CHK_W'(RC);
      low_cnt <= '0;
    end else begin
      low_cnt <= dram_ras_n ? '0 : low_cnt + 1'b1;
      if (!dram_ras_n && (low_cnt == '0)) gap_cnt <= CHK_W'(1);
      else if (gap_cnt < CHK_W'(RC))      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assert_ras_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (gap_cnt >= CHK_W'(RC)));

  assert_ras_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> (low_cnt >= CHK_W'(RAC)));

  assert_cbr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(!dram_cas_n) && dram_we_n));

  assert_write_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_oe_n);

  assert_wdata_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_dq_oe) && $past(!dram_we_n)));

  assert_refresh_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_IDLE) && ref_pending) |=> (state == S_RCAS));

  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: tb/test_edo_ctrl.sv
`timescale 1ns/1ps
module test_edo_ctrl;
  localparam int T_NS   = 5;
  localparam int REFI_N = 2000;
  localparam int T_RC   = int'($ceil(84.0 / T_NS));
  localparam int T_RAC  = int'($ceil(50.0 / T_NS));
  localparam int T_CAC  = int'($ceil(13.0 / T_NS));
  localparam int REFI_C = int'($ceil(real'(REFI_N) / T_NS));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = !clk;

  int checks = 0;
  int errors = 0;

  // ---------- main instance, 4K geometry ----------
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data, dq_out, dq_in;
  logic [11:0] ma;
  logic        ras_n, cas_n, we_n, oe_n, dq_oe;

  edo_ctrl #(.BIG_ROWS(1'b0), .GRADE(5), .CLK_NS(T_NS), .REFI_NS(REFI_N)) i_edo_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ma(ma), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  // ---------- second instance, 8K geometry ----------
  logic        k_valid = 1'b0;
  logic        k_ready, k_rdv, k_ras, k_cas, k_we, k_oe, k_dqoe;
  logic [7:0]  k_rdd, k_dqo;
  logic [12:0] k_ma;
  logic [22:0] k_addr = 23'h5A5A5A;

  edo_ctrl #(.BIG_ROWS(1'b1), .GRADE(5), .CLK_NS(T_NS), .REFI_NS(900000)) i_edo_ctrl_8k (
    .clk(clk), .rst_n(rst_n), .req_valid(k_valid), .req_ready(k_ready),
    .req_addr(k_addr), .req_write(1'b0), .req_wdata(8'h00),
    .rd_valid(k_rdv), .rd_data(k_rdd), .dram_ma(k_ma), .dram_ras_n(k_ras),
    .dram_cas_n(k_cas), .dram_we_n(k_we), .dram_oe_n(k_oe),
    .dram_dq_out(k_dqo), .dram_dq_oe(k_dqoe), .dram_dq_in(8'h00)
  );

  // ---------- behavioural DRAM model (evaluated at negedge) ----------
  logic [7:0] mem [logic [22:0]];
  logic       p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, in_ref = 1'b0;
  int         ras_cnt = 0, cas_cnt = 0, since_fall = 1000;
  logic [11:0] row_q = '0, last_row = '0;
  logic [10:0] last_col = '0;
  int         ref_count = 0, v_rc = 0, v_ras = 0, v_cbr = 0, v_oe = 0, v_wr = 0;
  int         last_ras_w = 0, last_cas_w = 0, last_rcd = 0;
  logic [12:0] k_row = '0, k_col = '0;
  logic        k_pras = 1'b1, k_pcas = 1'b1;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1'b1; p_cas = 1'b1; p_we = 1'b1; dq_in = 8'hEE;
    end else begin
      if (p_ras && !ras_n) begin
        if (since_fall < T_RC) v_rc++;
        since_fall = 1;
        if (!cas_n) begin
          ref_count++; in_ref = 1'b1;
          if (p_cas || !we_n) v_cbr++;
        end else row_q = ma;
      end else if (since_fall < 1000) since_fall++;
      if (p_cas && !cas_n && !ras_n) begin
        last_col = ma[10:0]; last_row = row_q; last_rcd = ras_cnt;
        if (!we_n) begin
          if (p_we || !dq_oe) v_wr++;
          mem[{row_q, ma[10:0]}] = dq_out;
        end
      end
      if (!we_n && !oe_n) v_oe++;
      if (!p_cas && cas_n && !in_ref) last_cas_w = cas_cnt;
      if (!p_ras && ras_n) begin
        if (ras_cnt < T_RAC) v_ras++;
        if (!in_ref) last_ras_w = ras_cnt;
        in_ref = 1'b0;
      end
      ras_cnt = ras_n ? 0 : ras_cnt + 1;
      cas_cnt = cas_n ? 0 : cas_cnt + 1;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
      if (!ras_n && !cas_n && !oe_n && we_n && ras_cnt >= T_RAC && cas_cnt >= T_CAC)
        dq_in = mem.exists({row_q, last_col}) ? mem[{row_q, last_col}] : 8'h00;
      else
        dq_in = 8'hEE;
    end
    if (k_pras && !k_ras) k_row = k_ma;
    if (k_pcas && !k_cas && !k_ras) k_col = k_ma;
    k_pras = k_ras; k_pcas = k_cas;
  end

  // ---------- check helpers ----------
  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(string req, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic issue(input logic [22:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    req_addr = a; req_write = w; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [22:0] a, output logic [7:0] d);
    int n;
    issue(a, 1'b0, 8'h00);
    n = 0;
    while (!rd_valid && n < 200) begin @(negedge clk); n++; end
    d = rd_data;
  endtask

  // stimulus table: address, write byte
  localparam int NV = 8;
  localparam logic [22:0] V_ADDR [NV] = '{23'h000000, 23'h7FFFFF, 23'h0007FF, 23'h000800,
                                          23'h123456, 23'h654321, 23'h400001, 23'h3FF800};
  localparam logic [7:0]  V_DATA [NV] = '{8'h11, 8'hFE, 8'h5A, 8'hA5,
                                          8'h3C, 8'hC3, 8'h7E, 8'h81};

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    int r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    chk("R2", "strobes", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk("R2", "req_ready", req_ready, 1);
    chk("R2", "rd_valid", rd_valid, 0);

    // table walk: writes, each with address split check
    for (int i = 0; i < NV; i++) begin
      issue(V_ADDR[i], 1'b1, V_DATA[i]);
      repeat (12) @(negedge clk);
      chk("R1", "write row", last_row, V_ADDR[i][22:11]);
      chk("R1", "write col", last_col, V_ADDR[i][10:0]);
    end
    // table walk: reads return written bytes
    for (int i = 0; i < NV; i++) begin
      do_read(V_ADDR[i], got);
      chk("R4", "read data", got, V_DATA[i]);
      chk("R1", "read col", last_col, V_ADDR[i][10:0]);
      chk("R3", "ras low width", last_ras_w, T_RAC);
    end

    // R3 / R10: strobe timing of an access, derived by ceiling
    do_read(V_ADDR[4], got);
    repeat (2) @(negedge clk);
    chk("R10", "ras-to-cas delay", last_rcd, T_RAC - T_CAC);
    chk("R3", "cas low width", last_cas_w, T_CAC);

    // R8: refresh rate while idle
    r0 = ref_count;
    repeat (5 * REFI_C) @(negedge clk);
    chk_rng("R8", "idle refreshes", ref_count - r0, 4, 6);

    // R9: refresh keeps its rate under back-to-back host reads
    @(negedge clk);
    req_addr = V_ADDR[5]; req_write = 1'b0; req_valid = 1'b1;
    r0 = ref_count;
    repeat (10 * REFI_C) @(negedge clk);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk_rng("R9", "refreshes under load", ref_count - r0, 9, 11);

    // data survives refresh traffic
    do_read(V_ADDR[1], got);
    chk("R4", "read after refresh", got, V_DATA[1]);

    // R1: 8K geometry split on the second instance
    @(negedge clk); k_valid = 1'b1;
    while (!k_ready) @(negedge clk);
    @(negedge clk); k_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1", "8K row", k_row, k_addr[22:10]);
    chk("R1", "8K col", k_col, {3'b000, k_addr[9:0]});

    // model-observed protocol rules
    chk("R6", "ras cycle violations", v_rc, 0);
    chk("R3", "ras width violations", v_ras, 0);
    chk("R7", "cbr order violations", v_cbr, 0);
    chk("R5", "oe during write", v_oe, 0);
    chk("R5", "write setup violations", v_wr, 0);
    chk_rng("R7", "refresh cycles seen", ref_count, 1, 1000);
    @(negedge clk);
    chk("R2", "idle strobes", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    finish_run();
  end

endmodule